// File: doc/BRIEF.md
# Programmable Threshold Flag Unit for a Dual-Clock FIFO

This block produces the two programmable occupancy flags of a dual-clock FIFO. One flag sits in the read clock domain and is high when the FIFO holds at least as many words as a programmable empty threshold. The other sits in the write clock domain and is high while the FIFO still has more free locations than a programmable full threshold. The occupancy counts reach the block already synchronized into each domain. Pointer storage, the memory array and the synchronizers belong to the surrounding FIFO.

The two thresholds sit in one shift register. Software or a test controller loads that register bit by bit over a small serial port, which has its own clock, an enable and a data input. The register is read back through a second enable and a data output, and readback does not disturb the stored values. At master reset, two select pins choose one of four threshold pairs. A partial reset clears the flags but keeps whatever thresholds have been programmed.

Top module: `fifo_thresh_flags`

## Requirements
- R1: While `mrst` is high on a `sclk` edge, both thresholds load the default picked by `dflt_sel`: 2'b00 gives 7, 2'b01 gives 31, 2'b10 gives 63, 2'b11 gives 127.
- R2: On each `sclk` rising edge with `ser_load_en` high, one bit from `ser_in` is shifted in. A complete 34-bit frame carries the empty threshold first and then the full threshold, each 17 bits wide and sent least significant bit first.
- R3: On each `sclk` rising edge with `ser_read_en` high and `ser_load_en` low, `ser_out` shows the next stored bit, in the same order as the load frame. The empty threshold's bit 0 appears after the first such edge. Reading a complete 34-bit frame leaves the thresholds unchanged.
- R4: When `ser_load_en` and `ser_read_en` are both high, the bit is loaded and `ser_out` holds its previous value.
- R5: A partial reset (`prst` high, `mrst` low) leaves both thresholds unchanged and forces `not_almost_empty` low and `not_almost_full` high.
- R6: On each `rclk` rising edge, `not_almost_empty` registers whether `rd_level` is greater than or equal to the empty threshold.
- R7: On each `wclk` rising edge, `not_almost_full` registers whether `DEPTH - wr_level` is strictly greater than the full threshold. It is low when the free count equals the threshold.
- R8: Under master reset, `not_almost_empty` is 0, `not_almost_full` is 1 and `ser_out` is 0.
- R9: With an empty threshold of 0, `not_almost_empty` is high even when `rd_level` is 0.
- R10: `not_almost_empty` changes only on `rclk` edges and `not_almost_full` only on `wclk` edges. A stopped read clock freezes the first flag while the second keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| sclk | input | 1 | Serial port clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| dflt_sel | input | 2 | Default threshold select, sampled during master reset |
| wr_level | input | CNT_W | Stored-word count seen in the write domain |
| rd_level | input | CNT_W | Stored-word count seen in the read domain |
| ser_load_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial load data |
| ser_read_en | input | 1 | Serial readback enable |
| ser_out | output | 1 | Serial readback data, registered |
| not_almost_empty | output | 1 | High when the stored words reach the empty threshold |
| not_almost_full | output | 1 | High when the free locations exceed the full threshold |

## Verification
The bench targets the exact threshold edges on both sides: a count one below, equal to and one above each threshold, a completely full FIFO, and an empty threshold of zero.
- An off-by-one comparison would flip a flag at exactly one of these edges.
- A reversed bit order or a swapped field order in the serial frame would read back the wrong thresholds.
- A destructive readback would fail the second readback.

Further checks cover the remaining corner cases:
- Load-over-read priority: a design that let reading win would change `ser_out` during a combined load.
- Partial reset: a design that cleared the thresholds on partial reset would read back defaults.
- Clock separation: freezing the read clock exposes a flag driven from the wrong domain.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

  typedef enum logic [1:0] {
    DSEL_7   = 2'b00,
    DSEL_31  = 2'b01,
    DSEL_63  = 2'b10,
    DSEL_127 = 2'b11
  } dflt_sel_e;

  // Default threshold for a select code.
  function automatic int unsigned dflt_thresh(input logic [1:0] sel);
    case (dflt_sel_e'(sel))
      DSEL_7:   return 7;
      DSEL_31:  return 31;
      DSEL_63:  return 63;
      default:  return 127;
    endcase
  endfunction

endpackage

// File: rtl/thresh_shift_reg.sv
module thresh_shift_reg
  import pflag_pkg::*;
#(
  parameter int OFS_W = 17
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic [1:0]       dflt_sel,
  input  logic             load_en,
  input  logic             load_bit,
  input  logic             read_en,
  output logic             ser_out,
  output logic [OFS_W-1:0] empty_thr,
  output logic [OFS_W-1:0] full_thr
);
  localparam int FRAME_W = 2 * OFS_W;

  logic [FRAME_W-1:0] frame_q;
  logic               so_q;
  logic [OFS_W-1:0]   dflt_w;

  assign dflt_w = OFS_W'(dflt_thresh(dflt_sel));

  // Frame layout: empty threshold in the low half, full threshold in the high half.
  // New bits enter at the top, so the first bit shifted in ends up at bit 0.
  always_ff @(posedge clk) begin
    if (mrst) begin
      frame_q <= {dflt_w, dflt_w};
      so_q    <= 1'b0;
    end else if (load_en) begin
      frame_q <= {load_bit, frame_q[FRAME_W-1:1]};
    end else if (read_en) begin
      frame_q <= {frame_q[0], frame_q[FRAME_W-1:1]};
      so_q    <= frame_q[0];
    end
  end

  assign ser_out   = so_q;
  assign empty_thr = frame_q[OFS_W-1:0];
  assign full_thr  = frame_q[FRAME_W-1:OFS_W];

  // R1: master reset leaves both thresholds on the same default.
  a_r1_dflt_pair: assert property (@(posedge clk)
    mrst |=> (empty_thr == full_thr));

  // R4: a combined load and read leaves the readback output still.
  a_r4_load_wins: assert property (@(posedge clk) disable iff (mrst)
    (load_en && read_en) |=> $stable(ser_out));

  // R5: partial reset alone does not touch the thresholds.
  a_r5_prst_keeps: assert property (@(posedge clk) disable iff (mrst)
    (prst && !load_en && !read_en) |=> ($stable(empty_thr) && $stable(full_thr)));

endmodule

// File: rtl/level_flag.sv
module level_flag #(
  parameter int CNT_W     = 18,
  parameter int OFS_W     = 17,
  parameter int DEPTH     = 131072,
  parameter bit FULL_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic [OFS_W-1:0] thr,
  output logic             flag
);
  localparam int CMP_W   = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;
  localparam bit RST_VAL = FULL_SIDE;

  logic [CMP_W-1:0] lvl_x;
  logic [CMP_W-1:0] thr_x;
  logic             hit;
  logic             flag_q;

  assign lvl_x = CMP_W'(level);
  assign thr_x = CMP_W'(thr);

  generate
    if (FULL_SIDE) begin : g_full
      logic [CMP_W-1:0] free_x;
      assign free_x = CMP_W'(DEPTH) - lvl_x;
      assign hit    = (free_x > thr_x);

      // R7: a completely full FIFO never reports room above the threshold.
      a_r7_no_room: assert property (@(posedge clk) disable iff (rst)
        (lvl_x == CMP_W'(DEPTH)) |=> !flag);
    end else begin : g_empty
      assign hit = (lvl_x >= thr_x);

      // R6: an empty FIFO with a nonzero threshold stays below it.
      a_r6_zero_level: assert property (@(posedge clk) disable iff (rst)
        ((lvl_x == '0) && (thr_x != '0)) |=> !flag);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= hit;
  end

  assign flag = flag_q;

  // R8: reset drives the flag to its idle value.
  a_r8_rst_value: assert property (@(posedge clk)
    rst |=> (flag == RST_VAL));

endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags #(
  parameter int DEPTH = 131072,
  parameter int OFS_W = 17,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             sclk,
  input  logic             mrst,
  input  logic             prst,
  input  logic [1:0]       dflt_sel,
  input  logic [CNT_W-1:0] wr_level,
  input  logic [CNT_W-1:0] rd_level,
  input  logic             ser_load_en,
  input  logic             ser_in,
  input  logic             ser_read_en,
  output logic             ser_out,
  output logic             not_almost_empty,
  output logic             not_almost_full
);
  logic [OFS_W-1:0] empty_thr;
  logic [OFS_W-1:0] full_thr;
  logic             any_rst;

  assign any_rst = mrst | prst;

  thresh_shift_reg #(.OFS_W(OFS_W)) u_thr (
    .clk       (sclk),
    .mrst      (mrst),
    .prst      (prst),
    .dflt_sel  (dflt_sel),
    .load_en   (ser_load_en),
    .load_bit  (ser_in),
    .read_en   (ser_read_en),
    .ser_out   (ser_out),
    .empty_thr (empty_thr),
    .full_thr  (full_thr)
  );

  level_flag #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FULL_SIDE(1'b0)) u_empty_side (
    .clk   (rclk),
    .rst   (any_rst),
    .level (rd_level),
    .thr   (empty_thr),
    .flag  (not_almost_empty)
  );

  level_flag #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FULL_SIDE(1'b1)) u_full_side (
    .clk   (wclk),
    .rst   (any_rst),
    .level (wr_level),
    .thr   (full_thr),
    .flag  (not_almost_full)
  );

endmodule

// File: tb/fifo_thresh_flags_bench.sv
module fifo_thresh_flags_bench;
  localparam int DEPTH = 131072;
  localparam int OFS_W = 17;
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int NVEC  = 6;
  // Vectors under default thresholds of 7: read level, write level, expected flags.
  localparam int V_RD  [NVEC] = '{0, 6, 7, 8, 131072, 3};
  localparam int V_WR  [NVEC] = '{0, 20, 131064, 131065, 131072, 131066};
  localparam int V_NAE [NVEC] = '{0, 0, 1, 1, 1, 0};
  localparam int V_NAF [NVEC] = '{1, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic r_run = 1'b1;
  logic rclk;
  logic mrst = 1'b1, prst = 1'b0;
  logic [1:0] dflt_sel = 2'b00;
  logic [CNT_W-1:0] wr_level = '0, rd_level = '0;
  logic ser_load_en = 1'b0, ser_in = 1'b0, ser_read_en = 1'b0;
  logic ser_out, not_almost_empty, not_almost_full;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;
  assign rclk = clk & r_run;

  fifo_thresh_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_fifo_thresh_flags (
    .wclk(clk), .rclk(rclk), .sclk(clk), .mrst(mrst), .prst(prst),
    .dflt_sel(dflt_sel), .wr_level(wr_level), .rd_level(rd_level),
    .ser_load_en(ser_load_en), .ser_in(ser_in), .ser_read_en(ser_read_en),
    .ser_out(ser_out), .not_almost_empty(not_almost_empty),
    .not_almost_full(not_almost_full)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ser_write(input logic [OFS_W-1:0] n, input logic [OFS_W-1:0] m);
    logic [2*OFS_W-1:0] fr;
    fr = {m, n};
    for (int i = 0; i < 2*OFS_W; i++) begin
      ser_load_en = 1'b1; ser_in = fr[i];
      tick();
    end
    ser_load_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic ser_read(output logic [OFS_W-1:0] n, output logic [OFS_W-1:0] m);
    logic [2*OFS_W-1:0] fr;
    ser_read_en = 1'b1;
    for (int i = 0; i < 2*OFS_W; i++) begin
      tick();
      fr[i] = ser_out;
    end
    ser_read_en = 1'b0;
    n = fr[OFS_W-1:0];
    m = fr[2*OFS_W-1:OFS_W];
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [OFS_W-1:0] rn, rm;
    logic s0;
    @(negedge clk); tick();
    // R8: reset state
    chk("R8 nae", not_almost_empty, 0);
    chk("R8 naf", not_almost_full, 1);
    chk("R8 ser_out", ser_out, 0);

    // R1: each default select, checked by readback
    for (int s = 3; s >= 0; s--) begin
      mrst = 1'b1; dflt_sel = 2'(s); tick();
      mrst = 1'b0; tick();
      ser_read(rn, rm);
      chk("R1 empty default", rn, (s == 0) ? 7 : (s == 1) ? 31 : (s == 2) ? 63 : 127);
      chk("R1 full default",  rm, (s == 0) ? 7 : (s == 1) ? 31 : (s == 2) ? 63 : 127);
    end

    // R6 R7: vector table with both thresholds at 7
    for (int v = 0; v < NVEC; v++) begin
      rd_level = CNT_W'(V_RD[v]); wr_level = CNT_W'(V_WR[v]);
      tick();
      chk($sformatf("R6 vec%0d", v), not_almost_empty, V_NAE[v]);
      chk($sformatf("R7 vec%0d", v), not_almost_full,  V_NAF[v]);
    end

    // R2 R3: serial load then two readbacks
    ser_write(17'h1A5C3, 17'h0F0E1);
    ser_read(rn, rm);
    chk("R2 empty loaded", rn, 17'h1A5C3);
    chk("R2 full loaded",  rm, 17'h0F0E1);
    ser_read(rn, rm);
    chk("R3 empty after readback", rn, 17'h1A5C3);
    chk("R3 full after readback",  rm, 17'h0F0E1);

    // Thresholds n=5, m=20 for boundary checks
    ser_write(17'd5, 17'd20);
    rd_level = 4; wr_level = 131051; tick();
    chk("R6 below threshold", not_almost_empty, 0);
    chk("R7 free one above", not_almost_full, 1);
    rd_level = 5; wr_level = 131052; tick();
    chk("R6 at threshold", not_almost_empty, 1);
    chk("R7 free equals threshold", not_almost_full, 0);

    // R10: stop read clock, flag must hold while write side tracks
    rd_level = 100; wr_level = 0; tick();
    r_run = 1'b0;
    rd_level = 0; wr_level = 131072;
    tick(); tick();
    chk("R10 nae frozen", not_almost_empty, 1);
    chk("R10 naf tracks", not_almost_full, 0);
    r_run = 1'b1; tick();
    chk("R10 nae resumes", not_almost_empty, 0);

    // R5: partial reset
    rd_level = 100; wr_level = 131072; tick();
    prst = 1'b1; tick();
    chk("R5 nae cleared", not_almost_empty, 0);
    chk("R5 naf set", not_almost_full, 1);
    prst = 1'b0; tick();
    ser_read(rn, rm);
    chk("R5 empty kept", rn, 5);
    chk("R5 full kept",  rm, 20);

    // R4: combined load and read
    s0 = ser_out;
    begin
      logic [2*OFS_W-1:0] fr;
      int moved;
      fr = {17'd9, 17'd3};
      moved = 0;
      for (int i = 0; i < 2*OFS_W; i++) begin
        ser_load_en = 1'b1; ser_read_en = 1'b1; ser_in = fr[i];
        tick();
        if (ser_out !== s0) moved++;
      end
      ser_load_en = 1'b0; ser_read_en = 1'b0;
      chk("R4 ser_out held", moved, 0);
    end
    ser_read(rn, rm);
    chk("R4 load applied empty", rn, 3);
    chk("R4 load applied full",  rm, 9);

    // R9: empty threshold of zero
    ser_write(17'd0, 17'd20);
    rd_level = 0; prst = 1'b1; tick();
    chk("R9 nae in reset", not_almost_empty, 0);
    prst = 1'b0; tick();
    chk("R9 nae at zero level", not_almost_empty, 1);

    report();
  end
endmodule